// File: doc/BRIEF.md
# Two-Best Track Candidate Sorter

Each bunch-crossing clock this block takes a set of track-segment candidates, two from each of four upstream correlator units (eight lanes in the default build). It returns the two best candidates on two output slots. A candidate has a valid flag, a signed bending angle, a position and a quality grade. The best candidate is the valid one whose bending angle is smallest in magnitude. Candidates with equal magnitude are ordered first by higher quality and then by lower lane number.

The result comes out a fixed two clocks after the inputs are sampled, and a new set of candidates can be offered on every clock. The output slots use the same field layout as an input lane. Several instances can therefore feed a second instance, built with a different lane count, that reduces their combined output to at most two candidates per crossing.

Top module: `trk_pair_sorter`

## Requirements
- R1: Lane i (0 to N_IN-1, default 8) occupies bit i of `cand_vld_i`, bits [i*10 +: 10] of `cand_ang_i` (a two's-complement angle), bits [i*12 +: 12] of `cand_pos_i` and bits [i*3 +: 3] of `cand_qual_i`. Output slot s (0 = best, 1 = runner-up) uses bit s of `best_vld_o` and the same field widths at offset s.
- R2: Slot 0 carries the valid candidate with the smallest angle magnitude. Slot 1 carries the smallest of the remaining valid candidates.
- R3: Angles are ranked by absolute value. Positive and negative angles of the same size rank equal, and -512 ranks behind +511.
- R4: Between candidates of equal angle magnitude, the one with the higher quality value ranks first.
- R5: Between candidates of equal angle magnitude and equal quality, the lower lane index ranks first.
- R6: A lane whose valid bit is 0 is never selected, whatever its angle, position and quality hold.
- R7: When fewer than two lanes are valid, each unused slot shows valid 0 with its angle, position and quality all zero. Slot 1 is never valid while slot 0 is not.
- R8: The inputs present at clock edge k appear on the outputs right after edge k+1. Back-to-back crossings are handled independently on every clock.
- R9: A synchronous active-high reset clears all outputs to zero. The outputs stay zero while reset is held, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| cand_vld_i | input | N_IN | Per-lane valid flags |
| cand_ang_i | input | N_IN*10 | Per-lane signed bending angles |
| cand_pos_i | input | N_IN*12 | Per-lane positions |
| cand_qual_i | input | N_IN*3 | Per-lane quality grades |
| best_vld_o | output | 2 | Valid flag per output slot |
| best_ang_o | output | 20 | Angle per output slot |
| best_pos_o | output | 24 | Position per output slot |
| best_qual_o | output | 6 | Quality per output slot |

## Verification
Each candidate set is driven half a clock before edge k, and its two winners are due right after edge k+1. The bench therefore keeps a two-deep queue of expected results and compares, at every falling edge, the outputs against the entry pushed two falling edges earlier. Reset checks look at the outputs one falling edge after reset is sampled and while it is still held. Directed crossings (sign symmetry, the -512 extreme, quality and lane ties, masked lanes, sparse valid sets) are interleaved with seeded random crossings on every clock, so that back-to-back independence is also covered.

// File: rtl/trk_sort_pkg.sv
package trk_sort_pkg;
  localparam int unsigned DEF_LANES  = 8;
  localparam int unsigned DEF_ANG_W  = 10;
  localparam int unsigned DEF_POS_W  = 12;
  localparam int unsigned DEF_QUAL_W = 3;
  localparam int unsigned SLOTS      = 2;
endpackage

// File: rtl/trk_rank_key.sv
// Builds an unsigned rank key per lane: a smaller key is a better candidate.
// Order of fields: invalid flag, angle magnitude, inverted quality, lane index.
module trk_rank_key #(
  parameter int unsigned ANG_W  = 10,
  parameter int unsigned QUAL_W = 3,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned LANE   = 0,
  localparam int unsigned KEY_W = 1 + ANG_W + QUAL_W + IDX_W
) (
  input  logic              vld,
  input  logic [ANG_W-1:0]  ang,
  input  logic [QUAL_W-1:0] qual,
  output logic [KEY_W-1:0]  key
);
  logic [ANG_W-1:0] mag;
  localparam logic [IDX_W-1:0] LANE_ID = IDX_W'(LANE);

  always_comb begin
    mag = ang[ANG_W-1] ? (~ang + 1'b1) : ang;
    key = {~vld, mag, ~qual, LANE_ID};
  end
endmodule

// File: rtl/trk_top2_pick.sv
// Picks the two smallest keys and registers the chosen payloads.
module trk_top2_pick #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned ANG_W  = 10,
  parameter int unsigned POS_W  = 12,
  parameter int unsigned QUAL_W = 3,
  localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int unsigned KEY_W = 1 + ANG_W + QUAL_W + IDX_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [KEY_W-1:0]         key_i  [N_IN],
  input  logic [N_IN*ANG_W-1:0]    ang_i,
  input  logic [N_IN*POS_W-1:0]    pos_i,
  input  logic [N_IN*QUAL_W-1:0]   qual_i,
  output logic [1:0]               vld_o,
  output logic [2*ANG_W-1:0]       ang_o,
  output logic [2*POS_W-1:0]       pos_o,
  output logic [2*QUAL_W-1:0]      qual_o
);
  logic [IDX_W-1:0] win0, win1;
  logic             ok0, ok1;

  always_comb begin
    win0 = '0;
    for (int i = 1; i < N_IN; i++) begin
      if (key_i[i] < key_i[win0]) win0 = IDX_W'(i);
    end
    win1 = (win0 == '0) ? IDX_W'(1) : '0;
    for (int i = 0; i < N_IN; i++) begin
      if ((IDX_W'(i) != win0) && (key_i[i] < key_i[win1])) win1 = IDX_W'(i);
    end
    ok0 = ~key_i[win0][KEY_W-1];
    ok1 = ~key_i[win1][KEY_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= '0;
      ang_o  <= '0;
      pos_o  <= '0;
      qual_o <= '0;
    end else begin
      vld_o <= {ok1, ok0};
      ang_o[0 +: ANG_W]       <= ok0 ? ang_i[win0*ANG_W +: ANG_W] : '0;
      ang_o[ANG_W +: ANG_W]   <= ok1 ? ang_i[win1*ANG_W +: ANG_W] : '0;
      pos_o[0 +: POS_W]       <= ok0 ? pos_i[win0*POS_W +: POS_W] : '0;
      pos_o[POS_W +: POS_W]   <= ok1 ? pos_i[win1*POS_W +: POS_W] : '0;
      qual_o[0 +: QUAL_W]     <= ok0 ? qual_i[win0*QUAL_W +: QUAL_W] : '0;
      qual_o[QUAL_W +: QUAL_W] <= ok1 ? qual_i[win1*QUAL_W +: QUAL_W] : '0;
    end
  end

  // Output-side magnitudes, computed independently of the rank keys.
  logic [ANG_W-1:0] om0, om1;
  always_comb begin
    om0 = ang_o[ANG_W-1] ? (~ang_o[0 +: ANG_W] + 1'b1) : ang_o[0 +: ANG_W];
    om1 = ang_o[2*ANG_W-1] ? (~ang_o[ANG_W +: ANG_W] + 1'b1) : ang_o[ANG_W +: ANG_W];
  end

  p_slot_order_r2: assert property (@(posedge clk) disable iff (rst)
    (vld_o == 2'b11) |-> (om0 <= om1));
  p_qual_tie_r4: assert property (@(posedge clk) disable iff (rst)
    ((vld_o == 2'b11) && (om0 == om1)) |-> (qual_o[0 +: QUAL_W] >= qual_o[QUAL_W +: QUAL_W]));
  p_slot_fill_r7: assert property (@(posedge clk) disable iff (rst)
    vld_o[1] |-> vld_o[0]);
  p_empty_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !vld_o[1] |-> ((ang_o[ANG_W +: ANG_W] == '0) && (pos_o[POS_W +: POS_W] == '0)
                   && (qual_o[QUAL_W +: QUAL_W] == '0)));
endmodule

// File: rtl/trk_pair_sorter.sv
module trk_pair_sorter
  import trk_sort_pkg::*;
#(
  parameter int unsigned N_IN   = DEF_LANES,
  parameter int unsigned ANG_W  = DEF_ANG_W,
  parameter int unsigned POS_W  = DEF_POS_W,
  parameter int unsigned QUAL_W = DEF_QUAL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN-1:0]        cand_vld_i,
  input  logic [N_IN*ANG_W-1:0]  cand_ang_i,
  input  logic [N_IN*POS_W-1:0]  cand_pos_i,
  input  logic [N_IN*QUAL_W-1:0] cand_qual_i,
  output logic [SLOTS-1:0]       best_vld_o,
  output logic [SLOTS*ANG_W-1:0] best_ang_o,
  output logic [SLOTS*POS_W-1:0] best_pos_o,
  output logic [SLOTS*QUAL_W-1:0] best_qual_o
);
  localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int unsigned KEY_W = 1 + ANG_W + QUAL_W + IDX_W;

  // Stage 1: sample the crossing.
  logic [N_IN-1:0]        s1_vld;
  logic [N_IN*ANG_W-1:0]  s1_ang;
  logic [N_IN*POS_W-1:0]  s1_pos;
  logic [N_IN*QUAL_W-1:0] s1_qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= '0;
      s1_ang  <= '0;
      s1_pos  <= '0;
      s1_qual <= '0;
    end else begin
      s1_vld  <= cand_vld_i;
      s1_ang  <= cand_ang_i;
      s1_pos  <= cand_pos_i;
      s1_qual <= cand_qual_i;
    end
  end

  logic [KEY_W-1:0] lane_key [N_IN];

  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    trk_rank_key #(
      .ANG_W (ANG_W),
      .QUAL_W(QUAL_W),
      .IDX_W (IDX_W),
      .LANE  (g)
    ) u_key (
      .vld (s1_vld[g]),
      .ang (s1_ang[g*ANG_W +: ANG_W]),
      .qual(s1_qual[g*QUAL_W +: QUAL_W]),
      .key (lane_key[g])
    );
  end

  // Stage 2: select and register the two winners.
  trk_top2_pick #(
    .N_IN  (N_IN),
    .ANG_W (ANG_W),
    .POS_W (POS_W),
    .QUAL_W(QUAL_W)
  ) u_pick (
    .clk   (clk),
    .rst   (rst),
    .key_i (lane_key),
    .ang_i (s1_ang),
    .pos_i (s1_pos),
    .qual_i(s1_qual),
    .vld_o (best_vld_o),
    .ang_o (best_ang_o),
    .pos_o (best_pos_o),
    .qual_o(best_qual_o)
  );

  // Reset history so the two-cycle check never reaches before reset.
  logic rst_d1 = 1'b1;
  logic rst_d2 = 1'b1;
  always_ff @(posedge clk) begin
    rst_d1 <= rst;
    rst_d2 <= rst_d1;
  end

  p_slot_count_r8: assert property (@(posedge clk) disable iff (rst || rst_d1 || rst_d2)
    $countones(best_vld_o) ==
      (($countones($past(cand_vld_i, 2)) > 1) ? 2 : $countones($past(cand_vld_i, 2))));
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (best_vld_o == '0));
endmodule

// File: tb/trk_pair_sorter_test.sv
module trk_pair_sorter_test;
  localparam int N  = 8;
  localparam int AW = 10;
  localparam int PW = 12;
  localparam int QW = 3;
  localparam int EW = 2 + 2*(AW + PW + QW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    vld = '0;
  logic [N*AW-1:0] ang = '0;
  logic [N*PW-1:0] pos = '0;
  logic [N*QW-1:0] qual = '0;
  logic [1:0]      o_vld;
  logic [2*AW-1:0] o_ang;
  logic [2*PW-1:0] o_pos;
  logic [2*QW-1:0] o_qual;

  int checks = 0;
  int failures = 0;

  logic [EW-1:0] pipe0 = '0, pipe1 = '0;
  string tag0 = "R8", tag1 = "R8";

  always #10 clk = ~clk;

  trk_pair_sorter uut (
    .clk(clk), .rst(rst),
    .cand_vld_i(vld), .cand_ang_i(ang), .cand_pos_i(pos), .cand_qual_i(qual),
    .best_vld_o(o_vld), .best_ang_o(o_ang), .best_pos_o(o_pos), .best_qual_o(o_qual)
  );

  function automatic int mag_of(input int i, input logic [N*AW-1:0] a);
    int x;
    x = $signed(a[i*AW +: AW]);
    return (x < 0) ? -x : x;
  endfunction

  function automatic logic [EW-1:0] model(input logic [N-1:0] v, input logic [N*AW-1:0] a,
                                          input logic [N*PW-1:0] p, input logic [N*QW-1:0] q);
    int b, s;
    logic [1:0] rv;
    logic [2*AW-1:0] ra;
    logic [2*PW-1:0] rp;
    logic [2*QW-1:0] rq;
    b = -1; s = -1;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        if (b < 0 || mag_of(i, a) < mag_of(b, a) ||
            (mag_of(i, a) == mag_of(b, a) && q[i*QW +: QW] > q[b*QW +: QW])) begin
          s = b; b = i;
        end else if (s < 0 || mag_of(i, a) < mag_of(s, a) ||
            (mag_of(i, a) == mag_of(s, a) && q[i*QW +: QW] > q[s*QW +: QW])) begin
          s = i;
        end
      end
    end
    rv = '0; ra = '0; rp = '0; rq = '0;
    if (b >= 0) begin
      rv[0] = 1'b1; ra[0 +: AW] = a[b*AW +: AW]; rp[0 +: PW] = p[b*PW +: PW]; rq[0 +: QW] = q[b*QW +: QW];
    end
    if (s >= 0) begin
      rv[1] = 1'b1; ra[AW +: AW] = a[s*AW +: AW]; rp[PW +: PW] = p[s*PW +: PW]; rq[QW +: QW] = q[s*QW +: QW];
    end
    return {rv, ra, rp, rq};
  endfunction

  task automatic check(input string req, input logic [EW-1:0] exp);
    logic [EW-1:0] act;
    act = {o_vld, o_ang, o_pos, o_qual};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One crossing: check the result due now, then drive the next set.
  task automatic step(input string req, input logic [N-1:0] v, input logic [N*AW-1:0] a,
                      input logic [N*PW-1:0] p, input logic [N*QW-1:0] q);
    @(negedge clk);
    check(tag1, pipe1);
    pipe1 = pipe0; tag1 = tag0;
    pipe0 = model(v, a, p, q); tag0 = req;
    vld = v; ang = a; pos = p; qual = q;
  endtask

  task automatic set_lane(inout logic [N-1:0] v, inout logic [N*AW-1:0] a,
                          inout logic [N*PW-1:0] p, inout logic [N*QW-1:0] q,
                          input int i, input int av, input int pv, input int qv);
    v[i] = 1'b1;
    a[i*AW +: AW] = AW'(av);
    p[i*PW +: PW] = PW'(pv);
    q[i*QW +: QW] = QW'(qv);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      vld = N'($urandom); ang = {$urandom, $urandom, $urandom};
      pos = {$urandom, $urandom, $urandom}; qual = N*QW'($urandom);
      if (k > 0) check("R9", '0);
    end
    @(negedge clk);
    check("R9", '0);
    vld = '0; ang = '0; pos = '0; qual = '0;
    rst = 1'b0;
    pipe0 = '0; pipe1 = '0; tag0 = "R9"; tag1 = "R9";
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [N-1:0] v;
    logic [N*AW-1:0] a;
    logic [N*PW-1:0] p;
    logic [N*QW-1:0] q;
    void'($urandom(32'd20240607));
    do_reset();

    // R7: nothing valid, garbage in lanes
    step("R7", '0, '1, '1, '1);
    // R1: only the top lane valid
    v = '0; a = '0; p = '0; q = '0;
    set_lane(v, a, p, q, 7, 37, 12'hABC, 5);
    step("R1", v, a, p, q);
    // R3: sign symmetry, negative on lower lane wins with equal quality
    v = '0; a = '0; p = '0; q = '0;
    set_lane(v, a, p, q, 2, -20, 100, 3);
    set_lane(v, a, p, q, 5, 20, 200, 3);
    set_lane(v, a, p, q, 6, 21, 300, 7);
    step("R3", v, a, p, q);
    // R3: -512 ranks behind +511
    v = '0; a = '0; p = '0; q = '0;
    set_lane(v, a, p, q, 0, -512, 11, 7);
    set_lane(v, a, p, q, 1, 511, 22, 0);
    step("R3", v, a, p, q);
    // R4: equal magnitude, higher quality on higher lane wins
    v = '0; a = '0; p = '0; q = '0;
    set_lane(v, a, p, q, 1, 9, 1, 2);
    set_lane(v, a, p, q, 4, -9, 4, 6);
    set_lane(v, a, p, q, 7, 9, 7, 4);
    step("R4", v, a, p, q);
    // R5: full tie, lower lanes win
    v = '0; a = '0; p = '0; q = '0;
    for (int i = 0; i < N; i++) set_lane(v, a, p, q, i, 3, 10 + i, 1);
    step("R5", v, a, p, q);
    // R6: masked lanes hold perfect-looking data
    a = '0; q = '1; p = '1;
    v = '0;
    set_lane(v, a, p, q, 3, 400, 33, 0);
    set_lane(v, a, p, q, 6, -300, 66, 0);
    step("R6", v, a, p, q);
    // R7: single valid lane, slot 1 empty
    v = '0; a = '0; p = '0; q = '0;
    set_lane(v, a, p, q, 0, -1, 4095, 7);
    step("R7", v, a, p, q);
    // R2: full set, distinct magnitudes
    v = '0; a = '0; p = '0; q = '0;
    for (int i = 0; i < N; i++) set_lane(v, a, p, q, i, (i % 2 == 0) ? 50 - i : i - 60, i * 7, i % 8);
    step("R2", v, a, p, q);

    // R8: random back-to-back crossings, some with narrow angles for ties
    for (int n = 0; n < 400; n++) begin
      v = N'($urandom);
      if (n % 5 == 0) v = '0;
      for (int i = 0; i < N; i++) begin
        a[i*AW +: AW] = (n % 3 == 0) ? AW'(int'($urandom % 8) - 4) : AW'($urandom);
        p[i*PW +: PW] = PW'($urandom);
        q[i*QW +: QW] = (n % 2 == 0) ? QW'($urandom % 2) : QW'($urandom);
      end
      step((n % 2 == 0) ? "R8" : "R2", v, a, p, q);
    end

    // R9: reset in mid-stream
    do_reset();
    v = '0; a = '0; p = '0; q = '0;
    set_lane(v, a, p, q, 2, 5, 55, 5);
    set_lane(v, a, p, q, 3, 6, 66, 6);
    step("R2", v, a, p, q);
    step("R8", '0, '0, '0, '0);
    step("R8", '0, '0, '0, '0);
    step("R8", '0, '0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule